// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a very small processor built around a single accumulator. It has its own 64-word by 8-bit memory, which holds both program and data. The processor touches that memory only through a 6-bit address register and an 8-bit data register. A control sequencer steps through fetch, decode and execute phases, and each phase performs one register transfer per clock.

Each instruction is one byte: a 2-bit operation code above a 6-bit direct address. There are four operations: load, store, add and jump. The surrounding logic writes a program into memory through a preload port while reset is held, then releases reset. Execution then begins at address 0. Every architectural register, the sequencer phase and one memory word chosen by an address input are brought out for observation.

Top module: `acc_cpu`

## Requirements
- R1: The memory has 64 words of 8 bits. When `pre_we` is high at a rising clock edge, word `pre_addr` takes `pre_data`. `obs_data` always shows the word selected by `obs_addr`.
- R2: A clock edge with `rst` high clears the accumulator, program counter, instruction register, address register and data register, and sets the phase to 0. Memory contents stay as they were.
- R3: Fetch takes three cycles. Phase 0 loads the address register from the program counter. Phase 1 loads the data register from memory at the address register. Phase 2 loads the instruction register from the data register and adds 1 to the program counter.
- R4: The operation code sits in instruction bits 7:6 and the address in bits 5:0. For codes 00, 01 and 10, phase 3 copies the address field into the address register.
- R5: Code 00 (load) reads memory into the data register in phase 4. In phase 5 it copies the data register into the accumulator. Each load instruction takes 6 cycles.
- R6: Code 01 (store) copies the accumulator into the data register in phase 4. In phase 5 it writes the data register to memory at the address register. The accumulator does not change. Each store takes 6 cycles.
- R7: Code 10 (add) reads memory into the data register in phase 4. In phase 5 it adds the data register to the accumulator modulo 256. No carry is kept. Each add takes 6 cycles.
- R8: Code 11 (jump) loads the address field into the program counter in phase 3 and then returns to phase 0. A jump takes 4 cycles and writes no memory.
- R9: The program counter wraps from 63 to 0 when it is incremented.
- R10: `phase_o` encodes the sequencer step: 0, 1 and 2 are fetch, 3 is decode/address, 4 and 5 are the two execute steps. No other value appears.
- R11: Take the program load 4, add 5, store 6, jump 1, with 1 in word 4 and 2 in word 5. Word 6 becomes 3 after the first store and grows by 2 on every later pass through the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 6 | Preload word address |
| pre_data | input | 8 | Preload word value |
| obs_addr | input | 6 | Address of the memory word to observe |
| obs_data | output | 8 | Observed memory word |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 6 | Program counter |
| ir_o | output | 8 | Instruction register |
| mar_o | output | 6 | Memory address register |
| mdr_o | output | 8 | Memory data register |
| phase_o | output | 3 | Sequencer phase |

## Verification
The bench builds the core with its default widths: 8-bit data, 6-bit addresses and 64 words. With these widths both wrap points can be reached by short programs. One program places code in the top three words so that the program counter runs off word 63 back to 0. Its data makes 200 + 100 overflow to 44. The reference loop runs several passes so that the growth of word 6 is seen at every instruction boundary, and a reset mid-run shows that memory survives.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam int OP_W   = DATA_W - ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [2:0] {
        PH_F0 = 3'd0,
        PH_F1 = 3'd1,
        PH_F2 = 3'd2,
        PH_X0 = 3'd3,
        PH_X1 = 3'd4,
        PH_X2 = 3'd5
    } phase_e;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADD   = 2'b10,
        OP_JUMP  = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic ma_pc;
        logic ma_ir;
        logic md_mem;
        logic md_acc;
        logic ir_ld;
        logic pc_inc;
        logic pc_jmp;
        logic ac_md;
        logic ac_add;
        logic mem_we;
    } ctrl_t;

    function automatic instr_t split_instr(input logic [DATA_W-1:0] w);
        return instr_t'(w);
    endfunction
endpackage

// File: rtl/acc_mem.sv
module acc_mem
    import acc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata,
    input  logic [AW-1:0] obs_addr,
    output logic [DW-1:0] obs_data
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] store_q [WORDS];

    // preload port wins over a core store in the same cycle
    always_ff @(posedge clk) begin
        if (pre_we)
            store_q[pre_addr] <= pre_data;
        else if (core_we)
            store_q[core_addr] <= core_wdata;
    end

    assign core_rdata = store_q[core_addr];
    assign obs_data   = store_q[obs_addr];
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_e    op,
    output phase_e phase,
    output ctrl_t  ctrl
);
    phase_e ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_F0:   ph_d = PH_F1;
            PH_F1:   ph_d = PH_F2;
            PH_F2:   ph_d = PH_X0;
            PH_X0:   ph_d = (op == OP_JUMP) ? PH_F0 : PH_X1;
            PH_X1:   ph_d = PH_X2;
            PH_X2:   ph_d = PH_F0;
            default: ph_d = PH_F0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_F0;
        else     ph_q <= ph_d;
    end

    always_comb begin
        ctrl = '0;
        case (ph_q)
            PH_F0: ctrl.ma_pc = 1'b1;
            PH_F1: ctrl.md_mem = 1'b1;
            PH_F2: begin
                ctrl.ir_ld  = 1'b1;
                ctrl.pc_inc = 1'b1;
            end
            PH_X0: begin
                if (op == OP_JUMP) ctrl.pc_jmp = 1'b1;
                else               ctrl.ma_ir  = 1'b1;
            end
            PH_X1: begin
                if (op == OP_STORE) ctrl.md_acc = 1'b1;
                else                ctrl.md_mem = 1'b1;
            end
            PH_X2: begin
                case (op)
                    OP_LOAD:  ctrl.ac_md  = 1'b1;
                    OP_ADD:   ctrl.ac_add = 1'b1;
                    OP_STORE: ctrl.mem_we = 1'b1;
                    default:  ;
                endcase
            end
            default: ;
        endcase
    end

    assign phase = ph_q;
endmodule

// File: rtl/acc_dp.sv
module acc_dp
    import acc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] ma,
    output logic [DW-1:0] md
);
    localparam logic [AW-1:0] PC_STEP = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            pc  <= '0;
            ir  <= '0;
            ma  <= '0;
            md  <= '0;
        end else begin
            if (ctrl.ma_pc)       ma <= pc;
            else if (ctrl.ma_ir)  ma <= ir[AW-1:0];

            if (ctrl.md_mem)      md <= rdata;
            else if (ctrl.md_acc) md <= acc;

            if (ctrl.ir_ld)       ir <= md;

            if (ctrl.pc_inc)      pc <= pc + PC_STEP;
            else if (ctrl.pc_jmp) pc <= ir[AW-1:0];

            if (ctrl.ac_md)       acc <= md;
            else if (ctrl.ac_add) acc <= acc + md;
        end
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic [AW-1:0] obs_addr,
    output logic [DW-1:0] obs_data,
    output logic [DW-1:0] acc_o,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] ir_o,
    output logic [AW-1:0] mar_o,
    output logic [DW-1:0] mdr_o,
    output logic [2:0]    phase_o
);
    ctrl_t         ctrl;
    phase_e        phase;
    instr_t        cur;
    logic [DW-1:0] rdata;

    assign cur = split_instr(ir_o);

    acc_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .op    (cur.op),
        .phase (phase),
        .ctrl  (ctrl)
    );

    acc_dp #(.DW(DW), .AW(AW)) u_dp (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .rdata (rdata),
        .acc   (acc_o),
        .pc    (pc_o),
        .ir    (ir_o),
        .ma    (mar_o),
        .md    (mdr_o)
    );

    acc_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk        (clk),
        .pre_we     (pre_we),
        .pre_addr   (pre_addr),
        .pre_data   (pre_data),
        .core_we    (ctrl.mem_we),
        .core_addr  (mar_o),
        .core_wdata (mdr_o),
        .core_rdata (rdata),
        .obs_addr   (obs_addr),
        .obs_data   (obs_data)
    );

    assign phase_o = phase;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [2:0]          phase,
    input logic [DATA_W-1:0]   acc,
    input logic [ADDR_W-1:0]   pc,
    input logic [DATA_W-1:0]   ir,
    input logic [ADDR_W-1:0]   mar,
    input logic [DATA_W-1:0]   mdr
);
    logic [OP_W-1:0] opc;
    assign opc = ir[DATA_W-1:ADDR_W];

    p_reset_clears_r2: assert property (@(posedge clk)
        rst |=> (acc == '0 && pc == '0 && ir == '0 && mar == '0 && mdr == '0 && phase == 3'd0));

    p_fetch_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0) |=> (mar == $past(pc) && phase == 3'd1));

    p_fetch_ir_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) |=> (ir == $past(mdr) && pc == ADDR_W'($past(pc) + 1'b1)));

    p_operand_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3 && opc != 2'b11) |=> (mar == $past(ir[ADDR_W-1:0]) && phase == 3'd4));

    p_store_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd5 && opc == 2'b01) |=> $stable(acc));

    p_add_wraps_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd5 && opc == 2'b10) |=> (acc == DATA_W'($past(acc) + $past(mdr))));

    p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3 && opc == 2'b11) |=> (pc == $past(ir[ADDR_W-1:0]) && phase == 3'd0));

    p_phase_legal_r10: assert property (@(posedge clk) disable iff (rst)
        phase <= 3'd5);
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_o),
    .acc   (acc_o),
    .pc    (pc_o),
    .ir    (ir_o),
    .mar   (mar_o),
    .mdr   (mdr_o)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [5:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [5:0] obs_addr = '0;
    logic [7:0] obs_data, acc_o, ir_o, mdr_o;
    logic [5:0] pc_o, mar_o;
    logic [2:0] phase_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] sm [64];
    logic [7:0] m_acc;
    logic [5:0] m_pc;

    acc_cpu i_acc_cpu (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .obs_addr(obs_addr), .obs_data(obs_data),
        .acc_o(acc_o), .pc_o(pc_o), .ir_o(ir_o), .mar_o(mar_o),
        .mdr_o(mdr_o), .phase_o(phase_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] peek(input logic [5:0] a);
        obs_addr = a;
        return 8'h00;
    endfunction

    task automatic read_word(input logic [5:0] a, output logic [7:0] v);
        obs_addr = a;
        #1;
        v = obs_data;
    endtask

    // clear memory and load a program, all while reset is held
    task automatic load_prog(input logic [7:0] img [64]);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) begin
            pre_we = 1'b1; pre_addr = 6'(i); pre_data = img[i];
            sm[i] = img[i];
            tick(1);
        end
        pre_we = 1'b0;
        tick(1);
        rst = 1'b0;
        m_acc = '0;
        m_pc  = '0;
    endtask

    // run one instruction in the bench model and on the core, then compare
    task automatic step_instr(input string req);
        logic [7:0] ins, w;
        logic [1:0] op;
        logic [5:0] a;
        int cyc;
        ins = sm[m_pc];
        op  = ins[7:6];
        a   = ins[5:0];
        m_pc = m_pc + 6'd1;
        cyc = 6;
        case (op)
            2'b00: m_acc = sm[a];
            2'b01: sm[a] = m_acc;
            2'b10: m_acc = m_acc + sm[a];
            default: begin m_pc = a; cyc = 4; end
        endcase
        tick(cyc);
        chk(req, "phase at boundary", {5'd0, phase_o}, 8'd0);
        chk(req, "acc", acc_o, m_acc);
        chk(req, "pc", {2'b00, pc_o}, {2'b00, m_pc});
        chk(req, "ir", ir_o, ins);
        read_word(a, w);
        chk(req, "operand word", w, sm[a]);
    endtask

    task automatic t_reset();
        logic [7:0] img [64];
        logic [7:0] w;
        for (int i = 0; i < 64; i++) img[i] = 8'(i * 3 + 1);
        load_prog(img);
        rst = 1'b1;
        tick(1);
        chk("R2", "acc after reset", acc_o, 8'd0);
        chk("R2", "pc after reset", {2'b00, pc_o}, 8'd0);
        chk("R2", "ir after reset", ir_o, 8'd0);
        chk("R2", "mar after reset", {2'b00, mar_o}, 8'd0);
        chk("R2", "mdr after reset", mdr_o, 8'd0);
        chk("R10", "phase after reset", {5'd0, phase_o}, 8'd0);
        read_word(6'd37, w);
        chk("R1", "preloaded word 37", w, 8'(37 * 3 + 1));
        read_word(6'd63, w);
        chk("R1", "preloaded word 63", w, 8'(63 * 3 + 1));
        rst = 1'b0;
    endtask

    task automatic t_fetch();
        logic [7:0] img [64];
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        img[0] = 8'b10_000011; img[3] = 8'd9;
        load_prog(img);
        tick(1);
        chk("R3", "mar after phase 0", {2'b00, mar_o}, 8'd0);
        chk("R10", "phase 1", {5'd0, phase_o}, 8'd1);
        tick(1);
        chk("R3", "mdr after phase 1", mdr_o, 8'b10_000011);
        tick(1);
        chk("R3", "ir after phase 2", ir_o, 8'b10_000011);
        chk("R3", "pc after phase 2", {2'b00, pc_o}, 8'd1);
        tick(1);
        chk("R4", "mar gets address field", {2'b00, mar_o}, 8'd3);
        chk("R10", "phase 4", {5'd0, phase_o}, 8'd4);
        tick(1);
        chk("R7", "mdr gets operand", mdr_o, 8'd9);
        tick(1);
        chk("R7", "acc after add", acc_o, 8'd9);
        chk("R10", "phase back to 0", {5'd0, phase_o}, 8'd0);
    endtask

    task automatic t_loop_program();
        logic [7:0] img [64];
        logic [7:0] w;
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        img[0] = 8'b00_000100;  // load 4
        img[1] = 8'b10_000101;  // add 5
        img[2] = 8'b01_000110;  // store 6
        img[3] = 8'b11_000001;  // jump 1
        img[4] = 8'd1;
        img[5] = 8'd2;
        load_prog(img);
        step_instr("R5");
        step_instr("R7");
        step_instr("R6");
        read_word(6'd6, w);
        chk("R11", "word 6 after first store", w, 8'd3);
        step_instr("R8");
        for (int k = 1; k <= 4; k++) begin
            step_instr("R7");
            step_instr("R6");
            read_word(6'd6, w);
            chk("R11", "word 6 after later pass", w, 8'(3 + 2 * k));
            step_instr("R8");
        end
        // a reset mid-run keeps memory and restarts at address 0
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R2", "acc cleared mid-run", acc_o, 8'd0);
        chk("R2", "pc cleared mid-run", {2'b00, pc_o}, 8'd0);
        read_word(6'd6, w);
        chk("R2", "word 6 kept over reset", w, 8'd11);
        m_acc = '0; m_pc = '0;
        step_instr("R5");
        chk("R5", "reload after reset", acc_o, 8'd1);
    endtask

    task automatic t_wraps();
        logic [7:0] img [64];
        logic [7:0] w;
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        img[0]  = 8'b11_111101;  // jump 61
        img[61] = 8'b00_111011;  // load 59
        img[62] = 8'b10_111100;  // add 60
        img[63] = 8'b01_111010;  // store 58
        img[59] = 8'd200;
        img[60] = 8'd100;
        load_prog(img);
        step_instr("R8");
        step_instr("R5");
        step_instr("R7");
        chk("R7", "200+100 wraps", acc_o, 8'd44);
        step_instr("R6");
        chk("R9", "pc wraps 63 to 0", {2'b00, pc_o}, 8'd0);
        read_word(6'd58, w);
        chk("R6", "stored wrapped sum", w, 8'd44);
        step_instr("R8");
        chk("R8", "jump again to 61", {2'b00, pc_o}, 8'd61);
        read_word(6'd0, w);
        chk("R8", "jump left word 0 unchanged", w, 8'b11_111101);
    endtask

    initial begin
        void'(peek(6'd0));
        t_reset();
        t_fetch();
        t_loop_program();
        t_wraps();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule